// File: doc/BRIEF.md
# Byte-Mask Flow Tag Generator

This block derives a 32-bit flow tag from a chosen subset of the leading bytes of each packet. Packets arrive one byte per beat with start and end markers. At the first beat a select input picks one of several byte masks. Every byte whose mask bit is set is folded into a CRC-32 accumulator. The CRC's starting value, its bit ordering and a final inversion are set by configuration inputs.

Each mask spans a fixed window of leading packet bytes and is stored as a row of eight-bit enable words in a small register file. A configuration port writes and reads these words, so a control agent can clear a mask and then set byte ranges by read-modify-write. When a packet ends, the finished tag is presented for one cycle with a valid strobe. A packet that starts uses the mask and CRC settings present on its first beat, so a change made mid-packet applies only from the next packet.

Top module: `tag_gen_top`

## Requirements
- R1: The mask store holds 4 masks of 16 eight-bit words, addressed as mask*16 + word. A write on `mask_we_i` stores `mask_wdata_i` at `mask_addr_i`. `mask_rdata_o` shows the word at `mask_addr_i` combinationally. Reset clears every word to zero.
- R2: Byte offset X of a packet (the start beat is offset 0) is included when bit 7-(X mod 8) of word X/8 of the chosen mask is set. The most significant bit of a word therefore enables its lowest offset.
- R3: The mask is chosen by `pkt_sel_i` on the start beat only. Its value on later beats has no effect.
- R4: With `crc_reflect_i`=0, bytes are processed most significant bit first with polynomial 0x04C11DB7. With initial value 0xFFFFFFFF and the bytes "123456789", the tag is 0xFC891918 when inverted and 0x0376E6E7 when not.
- R5: With `crc_reflect_i`=1, bytes are processed least significant bit first with the bit-reversed polynomial. For the same bytes and initial value, the tag is 0xCBF43926 when inverted and 0x340BC6D9 when not.
- R6: A packet with no enabled bytes yields the initial value, XORed with 0xFFFFFFFF when `crc_invert_i`=1.
- R7: Bytes at offset 128 and beyond are never included, however long the packet is.
- R8: `tag_valid_o` is high for exactly the cycle after the end beat. `tag_o` holds the tag from that cycle until the next end beat.
- R9: Mask writes and changes to the CRC settings made during a packet do not alter that packet's tag. They apply from the next packet.
- R10: Cycles with `pkt_valid_i` low are ignored, whatever the other packet inputs carry.
- R11: After reset `tag_valid_o` is 0 and `tag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Mask word write enable |
| mask_addr_i | input | 6 | Mask word address (mask*16 + word) |
| mask_wdata_i | input | 8 | Mask word write data |
| mask_rdata_o | output | 8 | Mask word at `mask_addr_i` |
| crc_iv_i | input | 32 | CRC initial value |
| crc_reflect_i | input | 1 | Process bytes least significant bit first |
| crc_invert_i | input | 1 | Invert the final CRC |
| pkt_valid_i | input | 1 | Packet byte present this cycle |
| pkt_sop_i | input | 1 | First byte of packet |
| pkt_eop_i | input | 1 | Last byte of packet |
| pkt_sel_i | input | 2 | Mask select, sampled on the start beat |
| pkt_data_i | input | 8 | Packet byte |
| tag_valid_o | output | 1 | Tag strobe, one cycle |
| tag_o | output | 32 | Flow tag |

## Verification
The bench builds the block with its default parameters: four masks of sixteen words, which gives a 128-byte window and a six-bit configuration address. With these values, a 140-byte packet reaches the window limit, and the last mask can stay untouched after reset to cover the empty-mask case. Two masks lay the same nine-byte pattern out contiguously and on odd offsets across three words, which checks the bit order inside each word and the word order. The known CRC-32 check values for all four combinations of reflection and inversion pin down both bit orders.

// File: rtl/tag_gen_pkg.sv
`timescale 1ns/1ps
package tag_gen_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY_NORM = 32'h04C11DB7;

  function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_REFL = bit_rev(POLY_NORM);

  typedef struct packed {
    logic [CRC_W-1:0] iv;
    logic             reflect;
    logic             invert;
  } crc_cfg_t;

  // one byte per call, shift-register form
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d,
                                                input logic refl);
    logic [CRC_W-1:0] r;
    if (refl) begin
      r = c ^ {{(CRC_W-8){1'b0}}, d};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    end else begin
      r = c ^ {d, {(CRC_W-8){1'b0}}};
      for (int b = 0; b < 8; b++) r = r[CRC_W-1] ? ((r << 1) ^ POLY_NORM) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tag_mask_rf.sv
`timescale 1ns/1ps
module tag_mask_rf #(
  parameter int NUM_MASKS  = 4,
  parameter int MASK_WORDS = 16,
  parameter int WORD_W     = 8,
  localparam int DEPTH  = NUM_MASKS * MASK_WORDS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SEL_W  = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [WORD_W-1:0]                   wdata_i,
  output logic [WORD_W-1:0]                   rdata_o,
  input  logic [SEL_W-1:0]                    sel_i,
  output logic [MASK_WORDS-1:0][WORD_W-1:0]   mask_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              addr_ok;

  assign addr_ok = {1'b0, addr_i} < (ADDR_W+1)'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
    end else if (we_i && addr_ok) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = addr_ok ? mem_q[addr_i] : '0;

  always_comb begin
    for (int w = 0; w < MASK_WORDS; w++)
      mask_o[w] = mem_q[ADDR_W'(sel_i) * ADDR_W'(MASK_WORDS) + ADDR_W'(w)];
  end

  // R1: a written word reads back on the next cycle
  a_r1_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(addr_ok) && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/tag_byte_sel.sv
`timescale 1ns/1ps
module tag_byte_sel #(
  parameter int MASK_WORDS = 16,
  parameter int WORD_W     = 8,
  localparam int MASK_BYTES = MASK_WORDS * WORD_W,
  localparam int OFF_W      = $clog2(MASK_BYTES + 1),
  localparam int IDX_W      = $clog2(MASK_BYTES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              beat_i,
  input  logic                              sop_i,
  input  logic [MASK_WORDS-1:0][WORD_W-1:0] live_mask_i,
  output logic                              byte_en_o
);
  logic [MASK_BYTES-1:0] live_flat, snap_q, use_flat;
  logic [OFF_W-1:0]      off_q, cur_off;
  logic                  in_window;

  // MSB of each word enables its lowest offset
  for (genvar x = 0; x < MASK_BYTES; x++) begin : g_flat
    assign live_flat[x] = live_mask_i[x / WORD_W][WORD_W - 1 - (x % WORD_W)];
  end

  assign cur_off   = sop_i ? '0 : off_q;
  assign use_flat  = sop_i ? live_flat : snap_q;
  assign in_window = cur_off < OFF_W'(MASK_BYTES);
  assign byte_en_o = beat_i && in_window && use_flat[cur_off[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      snap_q <= '0;
    end else if (beat_i) begin
      off_q <= in_window ? cur_off + 1'b1 : cur_off;
      if (sop_i) snap_q <= live_flat;
    end
  end

  // R7: once the window is passed no byte is ever enabled
  a_r7_window_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sop_i && off_q >= OFF_W'(MASK_BYTES)) |-> !byte_en_o);
endmodule

// File: rtl/tag_crc_acc.sv
`timescale 1ns/1ps
module tag_crc_acc
  import tag_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic             byte_en_i,
  input  logic [7:0]       data_i,
  input  crc_cfg_t         cfg_i,
  output logic             tag_valid_o,
  output logic [CRC_W-1:0] tag_o
);
  crc_cfg_t         cfg_q, cur_cfg;
  logic [CRC_W-1:0] crc_q, crc_in, crc_nx, tag_q;
  logic             valid_q;

  assign cur_cfg = sop_i ? cfg_i : cfg_q;
  assign crc_in  = sop_i ? cfg_i.iv : crc_q;
  assign crc_nx  = byte_en_i ? crc_step(crc_in, data_i, cur_cfg.reflect) : crc_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      crc_q   <= '0;
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= beat_i && eop_i;
      if (beat_i) begin
        crc_q <= crc_nx;
        if (sop_i) cfg_q <= cfg_i;
        if (eop_i) tag_q <= crc_nx ^ {CRC_W{cur_cfg.invert}};
      end
    end
  end

  assign tag_valid_o = valid_q;
  assign tag_o       = tag_q;

  // R8: tag only moves after an end beat
  a_r8_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(beat_i && eop_i) |-> $stable(tag_o));
endmodule

// File: rtl/tag_gen_top.sv
`timescale 1ns/1ps
module tag_gen_top
  import tag_gen_pkg::*;
#(
  parameter int NUM_MASKS  = 4,
  parameter int MASK_WORDS = 16,
  parameter int WORD_W     = 8,
  localparam int ADDR_W = $clog2(NUM_MASKS * MASK_WORDS),
  localparam int SEL_W  = (NUM_MASKS > 1) ? $clog2(NUM_MASKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [ADDR_W-1:0] mask_addr_i,
  input  logic [WORD_W-1:0] mask_wdata_i,
  output logic [WORD_W-1:0] mask_rdata_o,
  input  logic [CRC_W-1:0]  crc_iv_i,
  input  logic              crc_reflect_i,
  input  logic              crc_invert_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_sop_i,
  input  logic              pkt_eop_i,
  input  logic [SEL_W-1:0]  pkt_sel_i,
  input  logic [7:0]        pkt_data_i,
  output logic              tag_valid_o,
  output logic [CRC_W-1:0]  tag_o
);
  logic [MASK_WORDS-1:0][WORD_W-1:0] live_mask;
  logic                              byte_en;
  crc_cfg_t                          live_cfg;

  assign live_cfg = '{iv: crc_iv_i, reflect: crc_reflect_i, invert: crc_invert_i};

  tag_mask_rf #(
    .NUM_MASKS (NUM_MASKS),
    .MASK_WORDS(MASK_WORDS),
    .WORD_W    (WORD_W)
  ) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .addr_i (mask_addr_i),
    .wdata_i(mask_wdata_i),
    .rdata_o(mask_rdata_o),
    .sel_i  (pkt_sel_i),
    .mask_o (live_mask)
  );

  tag_byte_sel #(
    .MASK_WORDS(MASK_WORDS),
    .WORD_W    (WORD_W)
  ) i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (pkt_valid_i),
    .sop_i      (pkt_sop_i),
    .live_mask_i(live_mask),
    .byte_en_o  (byte_en)
  );

  tag_crc_acc i_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (pkt_valid_i),
    .sop_i      (pkt_sop_i),
    .eop_i      (pkt_eop_i),
    .byte_en_i  (byte_en),
    .data_i     (pkt_data_i),
    .cfg_i      (live_cfg),
    .tag_valid_o(tag_valid_o),
    .tag_o      (tag_o)
  );

  // R8: strobe follows every end beat
  a_r8_valid_after_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_eop_i) |=> tag_valid_o);
  // R8: strobe never without an end beat
  a_r8_valid_only_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_valid_o |-> $past(pkt_valid_i && pkt_eop_i));
  // R10: idle cycles raise no strobe
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !tag_valid_o);
endmodule

// File: tb/test_tag_gen_top.sv
`timescale 1ns/1ps
module test_tag_gen_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [5:0]  mask_addr_i = '0;
  logic [7:0]  mask_wdata_i = '0;
  logic [7:0]  mask_rdata_o;
  logic [31:0] crc_iv_i = '0;
  logic        crc_reflect_i = 1'b0;
  logic        crc_invert_i = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic        pkt_sop_i = 1'b0;
  logic        pkt_eop_i = 1'b0;
  logic [1:0]  pkt_sel_i = '0;
  logic [7:0]  pkt_data_i = '0;
  logic        tag_valid_o;
  logic [31:0] tag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  bm [64];
  int          mid_beat = -1;
  logic [5:0]  mid_addr;
  logic [7:0]  mid_data;
  logic [31:0] mid_iv;
  logic        got_v, got_v2;
  logic [31:0] got_tag;

  tag_gen_top i_tag_gen_top (.*);

  always #4 clk_i = ~clk_i;

  // {sel, reflect, invert, iv, layout, expected}
  localparam logic [68:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, 32'hFC891918},
    {2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h0376E6E7},
    {2'd0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 32'hCBF43926},
    {2'd0, 1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h340BC6D9},
    {2'd1, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 32'hCBF43926},
    {2'd1, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 32'hFC891918},
    {2'd2, 1'b1, 1'b1, 32'h12345678, 1'b0, 32'hEDCBA987},
    {2'd2, 1'b0, 1'b0, 32'h12345678, 1'b0, 32'h12345678}
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int layout, input int i);
    logic [7:0] junk = 8'hC0 ^ 8'(i);
    if (layout == 0) return (i < 9) ? 8'h31 + 8'(i) : junk;
    return (i % 2 == 1 && i < 18) ? 8'h31 + 8'((i - 1) / 2) : junk;
  endfunction

  // bit-serial reference built from R2, R4, R5, R6, R7
  function automatic logic [31:0] model(input logic [31:0] iv, input logic refl,
                                        input logic inv, input int sel, input int len,
                                        input int layout);
    logic [31:0] c = iv;
    for (int i = 0; i < len && i < 128; i++) begin
      if (bm[sel * 16 + i / 8][7 - i % 8]) begin
        logic [7:0] d = byte_at(layout, i);
        for (int k = 0; k < 8; k++) begin
          if (refl) c = (c >> 1) ^ ((c[0] ^ d[k]) ? 32'hEDB88320 : 32'h0);
          else      c = (c << 1) ^ ((c[31] ^ d[7-k]) ? 32'h04C11DB7 : 32'h0);
        end
      end
    end
    return inv ? ~c : c;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    mask_we_i = 1'b1; mask_addr_i = a; mask_wdata_i = d; bm[a] = d;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] iv, input logic refl, input logic inv);
    crc_iv_i = iv; crc_reflect_i = refl; crc_invert_i = inv;
  endtask

  task automatic send(input int sel, input int len, input int layout, input bit gap);
    for (int i = 0; i < len; i++) begin
      pkt_valid_i = 1'b1;
      pkt_sop_i   = (i == 0);
      pkt_eop_i   = (i == len - 1);
      pkt_sel_i   = (i == 0) ? 2'(sel) : 2'(sel) ^ 2'd1;
      pkt_data_i  = byte_at(layout, i);
      if (i == mid_beat) begin
        mask_we_i = 1'b1; mask_addr_i = mid_addr; mask_wdata_i = mid_data;
        bm[mid_addr] = mid_data; crc_iv_i = mid_iv;
      end
      @(negedge clk_i);
      mask_we_i = 1'b0;
      if (gap && i < len - 1) begin
        pkt_valid_i = 1'b0; pkt_sop_i = 1'b1; pkt_eop_i = 1'b1; pkt_data_i = 8'h31;
        @(negedge clk_i);
        if (tag_valid_o) check("R10", "strobe on idle", 32'(tag_valid_o), 32'd0);
      end
    end
    pkt_valid_i = 1'b0; pkt_sop_i = 1'b0; pkt_eop_i = 1'b0;
    got_v = tag_valid_o; got_tag = tag_o;
    @(negedge clk_i);
    got_v2 = tag_valid_o;
    mid_beat = -1;
  endtask

  task automatic expect_tag(input string req, input logic [31:0] exp);
    check("R8", "strobe after eop", 32'(got_v), 32'd1);
    check("R8", "strobe one cycle", 32'(got_v2), 32'd0);
    check(req, "tag", got_tag, exp);
    check("R8", "tag held", tag_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    for (int a = 0; a < 64; a++) bm[a] = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11", "valid in reset", 32'(tag_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", "valid after reset", 32'(tag_valid_o), 32'd0);
    check("R11", "tag after reset", tag_o, 32'd0);
    mask_addr_i = 6'd0;  #1 check("R1", "reset word 0", 32'(mask_rdata_o), 32'd0);
    mask_addr_i = 6'd63; #1 check("R1", "reset word 63", 32'(mask_rdata_o), 32'd0);
    @(negedge clk_i);

    // mask0: offsets 0..8; mask1: odd offsets 1..17
    wr(6'd0, 8'hFF); wr(6'd1, 8'h80);
    wr(6'd16, 8'h55); wr(6'd17, 8'h55); wr(6'd18, 8'h40);
    mask_addr_i = 6'd17; #1 check("R1", "readback", 32'(mask_rdata_o), 32'h55);
    @(negedge clk_i);

    // R2 R3 R4 R5 R6 table
    for (int v = 0; v < 8; v++) begin
      cfg(VEC[v][64:33], VEC[v][66], VEC[v][65]);
      send(int'(VEC[v][68:67]), 20, int'(VEC[v][32]), 1'b0);
      expect_tag(v < 4 ? "R4/R5" : (v < 6 ? "R2/R3" : "R6"), VEC[v][31:0]);
      @(negedge clk_i);
    end

    // R7: long packet, junk past offset 127
    cfg(32'hFFFFFFFF, 1'b1, 1'b1);
    send(0, 140, 0, 1'b0);
    expect_tag("R7", 32'hCBF43926);

    // R10: idle beats with junk between bytes
    cfg(32'hFFFFFFFF, 1'b0, 1'b1);
    send(0, 12, 0, 1'b1);
    expect_tag("R10", 32'hFC891918);

    // R9: mid-packet mask write and iv change
    cfg(32'hFFFFFFFF, 1'b1, 1'b1);
    mid_beat = 3; mid_addr = 6'd0; mid_data = 8'h00; mid_iv = 32'h0;
    send(0, 20, 0, 1'b0);
    expect_tag("R9", 32'hCBF43926);
    mask_addr_i = 6'd0; #1 check("R1", "mid write stored", 32'(mask_rdata_o), 32'h00);
    @(negedge clk_i);
    e = model(32'h0, 1'b1, 1'b1, 0, 20, 0);
    send(0, 20, 0, 1'b0);
    expect_tag("R9", e);

    // single-byte packet, sop and eop together
    wr(6'd0, 8'h80); wr(6'd1, 8'h00);
    cfg(32'h0, 1'b0, 1'b0);
    e = model(32'h0, 1'b0, 1'b0, 0, 1, 0);
    send(0, 1, 0, 1'b0);
    expect_tag("R4", e);

    // R6: untouched mask 3
    cfg(32'hA5A5F00F, 1'b1, 1'b1);
    send(3, 30, 0, 1'b0);
    expect_tag("R6", 32'h5A5A0FF0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule